// File: doc/BRIEF.md
# Oversampled Audio Decimation Chain

This block turns a one-bit sigma-delta stream, delivered at 128 times the audio output rate, into signed multibit PCM samples at the output rate for a single audio channel. Each stream bit is qualified by a strobe. A bit of 1 counts as +1 and a bit of 0 counts as -1. The first stage is a third-order sinc comb that divides the rate by 16 and reaches 8x. It is built as three running integrators and three one-sample differencers, so it needs no multipliers. Three half-band stages follow in cascade. Each one halves the rate and brings the stream down to 1x.

Every half-band stage uses the symmetric kernel (-1, 0, 9, 16, 9, 0, -1). Its centre tap is 16 and the sum is divided by 16 with a floor shift, so each stage has a DC gain of exactly 2. An input stream that is all ones gives +32768 at the output, and one that is all zeros gives -32768. The output word is 18 bits wide. A synchronous reset clears every delay line. A small control state machine then withholds the first samples, while the filter memories still hold reset zeros. The machine has three states:

- ST_IDLE: no strobe has arrived since reset. On the first strobe it moves to ST_FILL.
- ST_FILL: it counts the 1x samples from the last stage and suppresses them. When the sixth sample arrives it moves to ST_RUN.
- ST_RUN: every 1x sample is passed to the output. This state lasts until the next reset.

Top module: `audio_decim_chain`

## Requirements
- R1: While `rst` is high at a clock edge, `pcm_valid` and `pcm_out` read 0 after that edge, and every filter memory returns to zero.
- R2: A stream bit of 1 counts as +1 and a bit of 0 counts as -1. A steady all-ones stream settles at `pcm_out` = +32768, and a steady all-zeros stream settles at -32768.
- R3: The first stage forms the sum of stream values weighted by the 46-tap third-order sinc kernel (three 16-wide boxcars convolved). It emits one value on every 16th strobe, with zero history before reset.
- R4: Each half-band stage emits y = floor((-u[n] + 9u[n-2] + 16u[n-3] + 9u[n-4] - u[n-6]) / 16) only on its 2nd, 4th, 6th, ... input since reset. Here u[n] is the input just received, and inputs before reset count as zero.
- R5: Output sample j (0-based, counted from reset) is complete at strobe number 128j+127. `pcm_valid` is high for one cycle, exactly 4 clock edges after the edge that accepts that strobe.
- R6: The first 6 output samples after reset are suppressed. A run shorter than 7×128 strobes produces no `pcm_valid` at all.
- R7: `bit_in` is ignored in any cycle where `bit_en` is low.
- R8: No internal value overflows. The first stage output stays within ±4096, and the final samples match the exact integer results.
- R9: A reset applied while samples are still in flight cancels them, and the chain then restarts from a zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Strobe marking a valid stream bit (128x rate) |
| bit_in | input | 1 | Sigma-delta bit: 1 means +1, 0 means -1 |
| pcm_out | output | 18 | Signed PCM sample at 1x |
| pcm_valid | output | 1 | One-cycle pulse marking a new `pcm_out` |

## Verification
Each stage adds one register. The comb result for strobe 128j+127 is registered at the edge that accepts that strobe, the three half-band stages follow on the next three edges, and the output gate on the fourth. Sample j is therefore due exactly 4 edges after the accepting edge. The bench notes the edge number of every strobe it drives and the edge number of every `pcm_valid` it sees, sampling at the falling edge. It then requires each pulse to fall exactly on that 4-edge mark, and requires each value to equal a direct convolution model built from R3 and R4. The bench drives a reset right after the last strobe of a sample, so that the sample's pulse would have fallen inside the reset window, and then checks that no pulse appears.

// File: rtl/audio_decim_pkg.sv
package audio_decim_pkg;

    // Control states of the output gate.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_RUN
    } fill_state_t;

    // Half-band kernel: outer, inner and centre taps, plus the final shift.
    localparam int HB_OUTER  = -1;
    localparam int HB_INNER  = 9;
    localparam int HB_CENTER = 16;
    localparam int HB_SHIFT  = 4;
    localparam int HB_TAPS   = 6;   // delay registers behind the newest input

endpackage

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int DEC1  = 16,
    parameter int CIC_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    bit_in,
    output logic                    out_vld,
    output logic signed [CIC_W-1:0] out_dat
);

    localparam int CNT_W = $clog2(DEC1);

    logic signed [CIC_W-1:0] x_s;
    logic signed [CIC_W-1:0] i1, i2, i3;
    logic signed [CIC_W-1:0] i1n, i2n, i3n;
    logic signed [CIC_W-1:0] z0, z1, z2;
    logic signed [CIC_W-1:0] c1, c2, c3;
    logic [CNT_W-1:0]        cnt;

    // Map the bit to +1 / -1.
    assign x_s = bit_in ? CIC_W'(1) : CIC_W'(-1);

    // Integrators run in modular arithmetic; the differencers undo the wrap.
    always_comb begin
        i1n = i1 + x_s;
        i2n = i2 + i1n;
        i3n = i3 + i2n;
        c1  = i3n - z0;
        c2  = c1 - z1;
        c3  = c2 - z2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i1      <= '0;
            i2      <= '0;
            i3      <= '0;
            z0      <= '0;
            z1      <= '0;
            z2      <= '0;
            cnt     <= '0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= 1'b0;
            if (bit_en) begin
                i1 <= i1n;
                i2 <= i2n;
                i3 <= i3n;
                if (cnt == CNT_W'(DEC1 - 1)) begin
                    cnt     <= '0;
                    z0      <= i3n;
                    z1      <= c1;
                    z2      <= c2;
                    out_dat <= c3;
                    out_vld <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
    import audio_decim_pkg::*;
#(
    parameter int W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_dat,
    output logic                out_vld,
    output logic signed [W-1:0] out_dat
);

    localparam int ACC_W = W + 6;

    logic signed [W-1:0]     dly [0:HB_TAPS-1];
    logic                    odd;
    logic signed [ACC_W-1:0] k_out, k_in, k_mid, acc;

    assign k_out = ACC_W'(HB_OUTER);
    assign k_in  = ACC_W'(HB_INNER);
    assign k_mid = ACC_W'(HB_CENTER);

    // The zero taps at n-1 and n-5 are skipped; the symmetric pairs share one product.
    always_comb begin
        acc = k_out * (ACC_W'(in_dat) + ACC_W'(dly[5]))
            + k_in  * (ACC_W'(dly[1]) + ACC_W'(dly[3]))
            + k_mid * ACC_W'(dly[2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HB_TAPS; i++) dly[i] <= '0;
            odd     <= 1'b0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= in_vld & odd;
            if (in_vld) begin
                dly[0] <= in_dat;
                for (int i = 1; i < HB_TAPS; i++) dly[i] <= dly[i-1];
                odd <= ~odd;
                if (odd) out_dat <= W'(acc >>> HB_SHIFT);
            end
        end
    end

endmodule

// File: rtl/fill_gate.sv
module fill_gate
    import audio_decim_pkg::*;
#(
    parameter int W        = 18,
    parameter int FILL_OUT = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_dat,
    output logic                pcm_valid,
    output logic signed [W-1:0] pcm_out
);

    localparam int FC_W = $clog2(FILL_OUT + 1);

    fill_state_t     state;
    logic [FC_W-1:0] drop;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            drop  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (bit_en) state <= ST_FILL;
                ST_FILL: begin
                    if (in_vld) begin
                        if (drop == FC_W'(FILL_OUT - 1)) state <= ST_RUN;
                        else drop <= drop + 1'b1;
                    end
                end
                ST_RUN:  state <= ST_RUN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_valid <= 1'b0;
            pcm_out   <= '0;
        end else begin
            pcm_valid <= in_vld && (state == ST_RUN);
            if (in_vld && (state == ST_RUN)) pcm_out <= in_dat;
        end
    end

endmodule

// File: rtl/audio_decim_chain.sv
module audio_decim_chain #(
    parameter int DEC1     = 16,
    parameter int N_HB     = 3,
    parameter int OUT_W    = 18,
    parameter int FILL_OUT = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_en,
    input  logic                    bit_in,
    output logic signed [OUT_W-1:0] pcm_out,
    output logic                    pcm_valid
);

    localparam int CIC_W = 3 * $clog2(DEC1) + 2;

    logic                    cic_vld;
    logic signed [CIC_W-1:0] cic_dat;
    logic                    hb_vld [0:N_HB];
    logic signed [OUT_W-1:0] hb_dat [0:N_HB];

    sinc3_decim #(.DEC1(DEC1), .CIC_W(CIC_W)) u_sinc (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .out_vld (cic_vld),
        .out_dat (cic_dat)
    );

    assign hb_vld[0] = cic_vld;
    assign hb_dat[0] = OUT_W'(cic_dat);

    for (genvar s = 0; s < N_HB; s++) begin : g_hb
        hb_decim2 #(.W(OUT_W)) u_hb (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (hb_vld[s]),
            .in_dat  (hb_dat[s]),
            .out_vld (hb_vld[s+1]),
            .out_dat (hb_dat[s+1])
        );
    end

    fill_gate #(.W(OUT_W), .FILL_OUT(FILL_OUT)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .in_vld    (hb_vld[N_HB]),
        .in_dat    (hb_dat[N_HB]),
        .pcm_valid (pcm_valid),
        .pcm_out   (pcm_out)
    );

endmodule

// File: rtl/audio_decim_chk.sv
module audio_decim_chk #(
    parameter int DEC1     = 16,
    parameter int N_HB     = 3,
    parameter int CIC_W    = 14,
    parameter int FILL_OUT = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bit_en,
    input logic                    pcm_valid,
    input logic                    cic_vld,
    input logic signed [CIC_W-1:0] cic_dat
);

    localparam int LIM      = DEC1 * DEC1 * DEC1;
    localparam int MIN_BITS = DEC1 * (1 << N_HB) * (FILL_OUT + 1);

    int seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 0;
        else if (bit_en && seen < MIN_BITS) seen <= seen + 1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !pcm_valid); // R1

    AST_CIC_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        cic_vld |-> $past(bit_en)); // R3

    AST_CIC_RANGE: assert property (@(posedge clk) disable iff (rst)
        cic_vld |-> ($signed(cic_dat) <= LIM && $signed(cic_dat) >= -LIM)); // R8

    AST_VALID_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid); // R5

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> seen >= MIN_BITS); // R6

endmodule

bind audio_decim_chain audio_decim_chk #(
    .DEC1(DEC1), .N_HB(N_HB), .CIC_W(CIC_W), .FILL_OUT(FILL_OUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .pcm_valid (pcm_valid),
    .cic_vld   (cic_vld),
    .cic_dat   (cic_dat)
);

// File: tb/tb_audio_decim_chain.sv
`timescale 1ns/1ps
module tb_audio_decim_chain;

    localparam int FILL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [17:0] pcm_out;
    logic        pcm_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nbits = 0;
    int nout = 0;
    int xs [0:8191];
    int bit_cyc [0:8191];
    int act_val [0:127];
    int act_cyc [0:127];
    int kern [0:45];
    int stg [0:3][0:511];

    audio_decim_chain dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .pcm_out(pcm_out), .pcm_valid(pcm_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (pcm_valid && nout < 128) begin
            act_val[nout] = $signed(pcm_out);
            act_cyc[nout] = cyc;
            nout++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int getv(input int s, input int i);
        return (i < 0) ? 0 : stg[s][i];
    endfunction

    function automatic int getx(input int i);
        return (i < 0) ? 0 : xs[i];
    endfunction

    task automatic build_model();
        int ncic = nbits / 16;
        int nin;
        for (int m = 0; m < ncic; m++) begin
            int acc = 0;
            for (int k = 0; k < 46; k++) acc += kern[k] * getx(16*m + 15 - k);
            stg[0][m] = acc;
        end
        nin = ncic;
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < nin / 2; k++) begin
                int n = 2*k + 1;
                int sum = -getv(s, n) + 9*getv(s, n-2) + 16*getv(s, n-3)
                          + 9*getv(s, n-4) - getv(s, n-6);
                stg[s+1][k] = sum >>> 4;
            end
            nin = nin / 2;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(pcm_valid == 1'b0, "R1 valid in reset", int'(pcm_valid), 0);
        chk(pcm_out == 18'd0, "R1 out in reset", $signed(pcm_out), 0);
        rst = 1'b0;
    endtask

    task automatic clear_run();
        nbits = 0;
        nout = 0;
    endtask

    task automatic send_bit(input bit b, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = 1'($urandom % 2);
        end
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        xs[nbits] = b ? 1 : -1;
        bit_cyc[nbits] = cyc + 1;
        nbits++;
    endtask

    task automatic idle(input int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic finish_run(input string tag, input int force_cnt,
                              input bit use_const, input int const_exp);
        int exp_n;
        int lim;
        build_model();
        exp_n = (force_cnt >= 0) ? force_cnt : ((nbits / 128 > FILL) ? nbits / 128 - FILL : 0);
        chk(nout == exp_n, {tag, " R6 output count"}, nout, exp_n);
        lim = (nout < exp_n) ? nout : exp_n;
        for (int i = 0; i < lim; i++) begin
            int j = i + FILL;
            chk(act_val[i] == stg[3][j], {tag, " R3 R4 R8 sample value"}, act_val[i], stg[3][j]);
            chk(act_cyc[i] == bit_cyc[128*j + 127] + 4, {tag, " R5 sample timing"},
                act_cyc[i], bit_cyc[128*j + 127] + 4);
            if (use_const)
                chk(act_val[i] == const_exp, {tag, " R2 settled level"}, act_val[i], const_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 200000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 46; k++) kern[k] = 0;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 16; c++) kern[a+b+c]++;

        // R1: reset state
        do_reset();
        clear_run();

        // R6: too short a run gives no samples
        for (int i = 0; i < 850; i++) send_bit(1'b1, 0);
        idle(20);
        finish_run("short", 0, 1'b0, 0);
        do_reset();
        clear_run();

        // R2: all ones, back to back
        for (int i = 0; i < 40*128; i++) send_bit(1'b1, 0);
        idle(20);
        finish_run("ones", -1, 1'b1, 32768);
        do_reset();
        clear_run();

        // R2: all zeros with idle gaps
        for (int i = 0; i < 24*128; i++) send_bit(1'b0, i % 3);
        idle(20);
        finish_run("zeros", -1, 1'b1, -32768);
        do_reset();
        clear_run();

        // R7: random stream, random gaps with toggling bit_in
        for (int i = 0; i < 40*128; i++) send_bit(1'($urandom % 2), int'($urandom % 3));
        idle(20);
        finish_run("R7 random gaps", -1, 1'b0, 0);
        do_reset();
        clear_run();

        // R3 R4: dense stream biased high
        for (int i = 0; i < 24*128; i++) send_bit(($urandom % 100) < 80, 0);
        idle(20);
        finish_run("dense", -1, 1'b0, 0);
        do_reset();
        clear_run();

        // R9: reset lands while sample 7 is in flight
        for (int i = 0; i < 8*128; i++) send_bit(1'($urandom % 2), 0);
        do_reset();
        idle(20);
        chk(nout == 1, "R9 in-flight sample cancelled", nout, 1);
        finish_run("R9 restart", 1, 1'b0, 0);
        clear_run();
        for (int i = 0; i < 10*128; i++) send_bit(1'($urandom % 2), 0);
        idle(20);
        finish_run("R9 after reset", -1, 1'b0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule